// File: doc/BRIEF.md
# Six-Stage Instruction Pipeline Tracker with Late Branch Squash

This block follows instructions through a six-stage in-order pipeline. The stages are instruction fetch, decode, operand address calculation, operand fetch, execute and operand write-back. It computes no data. Each stage holds a valid bit and the instruction's tag, branch flag, resolved taken flag and branch target. An instruction source offers one instruction per clock, and the tracker moves every occupant one stage forward on each clock that is not stalled. It retires the occupant of the write-back stage and keeps counts of retirements and clocks.

Conditional branches are resolved only when they reach the write-back stage. A taken branch retires and raises a redirect strobe that carries its target tag. The same clock edge discards every younger instruction, including the one offered at the input on that cycle. The source is expected to present the target tag on the next clock. A stall input freezes every stage in place.

Top module: `pipe6_tracker`

## Requirements
- R1: While reset is asserted and after its release, before any instruction enters, all six stage valid bits are zero, `retire_valid` and `redirect` are low, and both counters read zero.
- R2: An instruction accepted at a clock edge (in_valid high, stall low) appears on `retire_valid`/`retire_tag` after exactly five further unstalled edges, and retires on the sixth. A cycle with in_valid low inserts a bubble that never retires.
- R3: With no branches or stalls, instructions retire in issue order, one per clock. If nine instructions are accepted on the first nine edges after reset release, the ninth is presented for retirement while `cycle_count` reads 14.
- R4: When a valid instruction in the write-back stage has its branch flag and taken flag both set and stall is low, `redirect` is high and `redirect_tag` equals that instruction's target. After that edge, all six stage valid bits are zero, so neither the five younger instructions nor the input of that cycle ever retires.
- R5: A branch whose taken flag is low never raises `redirect` and squashes nothing. A branch that is itself squashed never redirects.
- R6: While stall is high, no stage changes, the input is ignored, `retire_valid` and `redirect` are low, and no bubble is inserted.
- R7: `retired_count` (16 bits) increments by one on every edge at which `retire_valid` is high, and is otherwise unchanged.
- R8: `cycle_count` (16 bits) increments by one on every clock edge after reset release, stalled or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze all stages for this cycle |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_tag | input | TAG_W | Tag of the offered instruction |
| in_branch | input | 1 | Offered instruction is a conditional branch |
| in_taken | input | 1 | Resolved outcome of that branch (1 = taken) |
| in_target | input | TAG_W | Tag fetch restarts at if the branch is taken |
| retire_valid | output | 1 | Write-back stage retires its occupant on this edge |
| retire_tag | output | TAG_W | Tag of the retiring instruction |
| redirect | output | 1 | Taken branch retiring; younger stages squashed |
| redirect_tag | output | TAG_W | Target tag for the restarted fetch |
| stage_valid | output | 6 | Valid bit per stage, bit 0 = fetch, bit 5 = write-back |
| retired_count | output | CNT_W | Retired instruction count |
| cycle_count | output | CNT_W | Clock count since reset release |

## Verification
The stimulus includes a taken branch followed by a full stream of younger work. A design that cleared too few stages would let one of the squashed tags retire. A design that failed to kill the input of the flush cycle would retire the instruction offered on that edge. A second taken branch sits inside the first branch's shadow, so a design that let a squashed branch redirect would raise a spurious second redirect. A stall is applied with the pipeline full and a tag held on the input. A design that inserted bubbles, kept retiring, or latched that input would show missing or extra retirements, or a change in the valid pattern. The nine-instruction run right after reset catches an extra register in the path as an off-by-one in the cycle count.

// File: rtl/pipe6_pkg.sv
package pipe6_pkg;

  // Stage positions; the order is the flow order of the pipeline.
  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_ADDR   = 3'd2,
    ST_OPND   = 3'd3,
    ST_EXEC   = 3'd4,
    ST_WRITE  = 3'd5
  } stage_e;

  localparam int unsigned NUM_STAGES = 6;
  localparam int unsigned LAST_STAGE = NUM_STAGES - 1;

  // Number of flag bits carried beside the two tags in a slot payload.
  localparam int unsigned FLAG_BITS = 2;

  function automatic int unsigned payload_width(int unsigned tag_w);
    return FLAG_BITS + 2 * tag_w;
  endfunction

endpackage

// File: rtl/pipe6_slot.sv
module pipe6_slot #(
  parameter int unsigned PW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          kill,
  input  logic          d_valid,
  input  logic [PW-1:0] d_payload,
  output logic          q_valid,
  output logic [PW-1:0] q_payload
);

  logic          valid_nxt;
  logic [PW-1:0] payload_nxt;

  always_comb begin
    valid_nxt   = q_valid;
    payload_nxt = q_payload;
    if (adv) begin
      valid_nxt   = d_valid & ~kill;
      payload_nxt = d_payload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_payload <= '0;
    end else begin
      q_valid   <= valid_nxt;
      q_payload <= payload_nxt;
    end
  end

endmodule

// File: rtl/pipe6_ctrl.sv
module pipe6_ctrl (
  input  logic stall,
  input  logic wb_valid,
  input  logic wb_branch,
  input  logic wb_taken,
  output logic adv,
  output logic retire,
  output logic squash
);

  always_comb begin
    adv    = ~stall;
    retire = wb_valid & ~stall;
    squash = wb_valid & wb_branch & wb_taken & ~stall;
  end

endmodule

// File: rtl/pipe6_counter.sv
module pipe6_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] count_nxt;

  always_comb begin
    count_nxt = count;
    if (inc) count_nxt = count + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

endmodule

// File: rtl/pipe6_tracker.sv
module pipe6_tracker #(
  parameter int unsigned TAG_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                stall,
  input  logic                                in_valid,
  input  logic [TAG_W-1:0]                    in_tag,
  input  logic                                in_branch,
  input  logic                                in_taken,
  input  logic [TAG_W-1:0]                    in_target,
  output logic                                retire_valid,
  output logic [TAG_W-1:0]                    retire_tag,
  output logic                                redirect,
  output logic [TAG_W-1:0]                    redirect_tag,
  output logic [pipe6_pkg::NUM_STAGES-1:0]    stage_valid,
  output logic [CNT_W-1:0]                    retired_count,
  output logic [CNT_W-1:0]                    cycle_count
);
  import pipe6_pkg::*;

  localparam int unsigned PW      = payload_width(TAG_W);
  localparam int unsigned TAG_LO  = 0;
  localparam int unsigned TGT_LO  = TAG_W;
  localparam int unsigned BR_BIT  = 2 * TAG_W;
  localparam int unsigned TK_BIT  = 2 * TAG_W + 1;

  logic [PW-1:0] in_payload;
  logic [PW-1:0] slot_payload [NUM_STAGES];
  logic          slot_valid   [NUM_STAGES];

  logic adv;
  logic retire;
  logic squash;

  assign in_payload = {in_taken, in_branch, in_target, in_tag};

  genvar gi;
  generate
    for (gi = 0; gi < NUM_STAGES; gi++) begin : g_slot
      if (gi == 0) begin : g_head
        pipe6_slot #(.PW(PW)) u_slot (
          .clk       (clk),
          .rst_n     (rst_n),
          .adv       (adv),
          .kill      (squash),
          .d_valid   (in_valid),
          .d_payload (in_payload),
          .q_valid   (slot_valid[gi]),
          .q_payload (slot_payload[gi])
        );
      end else begin : g_body
        pipe6_slot #(.PW(PW)) u_slot (
          .clk       (clk),
          .rst_n     (rst_n),
          .adv       (adv),
          .kill      (squash),
          .d_valid   (slot_valid[gi-1]),
          .d_payload (slot_payload[gi-1]),
          .q_valid   (slot_valid[gi]),
          .q_payload (slot_payload[gi])
        );
      end
      assign stage_valid[gi] = slot_valid[gi];
    end
  endgenerate

  pipe6_ctrl u_ctrl (
    .stall     (stall),
    .wb_valid  (slot_valid[LAST_STAGE]),
    .wb_branch (slot_payload[LAST_STAGE][BR_BIT]),
    .wb_taken  (slot_payload[LAST_STAGE][TK_BIT]),
    .adv       (adv),
    .retire    (retire),
    .squash    (squash)
  );

  pipe6_counter #(.W(CNT_W)) u_retired (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (retire),
    .count (retired_count)
  );

  pipe6_counter #(.W(CNT_W)) u_cycles (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (1'b1),
    .count (cycle_count)
  );

  assign retire_valid = retire;
  assign retire_tag   = slot_payload[LAST_STAGE][TAG_LO +: TAG_W];
  assign redirect     = squash;
  assign redirect_tag = slot_payload[LAST_STAGE][TGT_LO +: TAG_W];

endmodule

// File: rtl/pipe6_tracker_chk.sv
module pipe6_tracker_chk #(
  parameter int unsigned TAG_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             retire_valid,
  input logic             redirect,
  input logic [5:0]       stage_valid,
  input logic [CNT_W-1:0] retired_count,
  input logic [CNT_W-1:0] cycle_count
);

  // R4: a redirect empties every stage on the following cycle
  p_squash_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (stage_valid == 6'b0));

  // R2: without stall or redirect the valid pattern shifts one stage
  p_shift_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redirect) |=> (stage_valid[5:1] == $past(stage_valid[4:0])));

  // R6: stalled stages hold still
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(stage_valid));

  // R6: nothing retires or redirects under stall
  p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!retire_valid && !redirect));

  // R5: a redirect only accompanies a retirement
  p_redirect_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> retire_valid);

  // R7: retirement count steps by one per retirement
  p_ret_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> (retired_count == $past(retired_count) + 1'b1));

  // R7: no retirement leaves the count alone
  p_ret_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_valid |=> $stable(retired_count));

  // R8: cycle count advances every clock
  p_cycle_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cycle_count == $past(cycle_count) + 1'b1));

endmodule

bind pipe6_tracker pipe6_tracker_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall         (stall),
  .retire_valid  (retire_valid),
  .redirect      (redirect),
  .stage_valid   (stage_valid),
  .retired_count (retired_count),
  .cycle_count   (cycle_count)
);

// File: tb/tb_pipe6_tracker.sv
module tb_pipe6_tracker;
  localparam int unsigned TAG_W = 8;
  localparam int unsigned CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             stall = 1'b0;
  logic             in_valid = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             in_branch = 1'b0;
  logic             in_taken = 1'b0;
  logic [TAG_W-1:0] in_target = '0;
  logic             retire_valid;
  logic [TAG_W-1:0] retire_tag;
  logic             redirect;
  logic [TAG_W-1:0] redirect_tag;
  logic [5:0]       stage_valid;
  logic [CNT_W-1:0] retired_count;
  logic [CNT_W-1:0] cycle_count;

  pipe6_tracker #(.TAG_W(TAG_W), .CNT_W(CNT_W)) dut (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [TAG_W-1:0] tag;
    logic             tk;
    logic [TAG_W-1:0] tgt;
    int               cyc;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   squash_left = 0;
  int   popped = 0;
  bit   mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Drive one cycle of input without waiting; model squash and queue expectations.
  task automatic drive_now(input bit v, input int tag, input bit br, input bit tk,
                           input int tgt, input bit stl, input int cyc);
    exp_t e;
    stall = stl; in_valid = v; in_tag = tag[TAG_W-1:0];
    in_branch = br; in_taken = tk; in_target = tgt[TAG_W-1:0];
    if (!stl) begin
      if (squash_left > 0) begin
        squash_left--;
      end else if (v) begin
        e.tag = tag[TAG_W-1:0]; e.tk = br & tk; e.tgt = tgt[TAG_W-1:0]; e.cyc = cyc;
        exp_q.push_back(e);
        if (br && tk) squash_left = 6;
      end
    end
  endtask

  task automatic issue(input bit v, input int tag, input bit br, input bit tk,
                       input int tgt, input bit stl);
    @(negedge clk);
    drive_now(v, tag, br, tk, tgt, stl, 0);
  endtask

  task automatic bubbles(input int n);
    for (int i = 0; i < n; i++) issue(1'b0, 0, 1'b0, 1'b0, 0, 1'b0);
  endtask

  // Monitor: sample 1 ns after each falling edge, 1 ns before the rising edge.
  initial begin
    logic [5:0] prev_sv = '0;
    bit prev_stall = 1'b0;
    bit prev_redir = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (mon_on) begin
        if (prev_stall) chk(stage_valid == prev_sv, "R6 hold", stage_valid, prev_sv);
        if (prev_redir) chk(stage_valid == 6'b0, "R4 cleared", stage_valid, 0);
        if (stall) chk(!retire_valid && !redirect, "R6 quiet", retire_valid, 0);
        if (retire_valid) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected retire", retire_tag, -1);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            popped++;
            chk(retire_tag == e.tag, "R2 retire tag", retire_tag, e.tag);
            if (e.cyc != 0) chk(cycle_count == e.cyc, "R3 cycle", cycle_count, e.cyc);
            chk(redirect == e.tk, "R4/R5 redirect", redirect, e.tk);
            if (e.tk) chk(redirect_tag == e.tgt, "R4 target", redirect_tag, e.tgt);
          end
        end else begin
          chk(!redirect, "R5 no redirect", redirect, 0);
        end
      end
      prev_sv = stage_valid; prev_stall = stall; prev_redir = redirect;
    end
  end

  initial begin
    fork
      begin
        #20;
        // R1: reset state
        chk(stage_valid == 6'b0, "R1 valid", stage_valid, 0);
        chk(retired_count == 0 && cycle_count == 0, "R1 counts", retired_count, 0);
        chk(!retire_valid && !redirect, "R1 outputs", retire_valid, 0);
        // R3: nine back-to-back instructions from the first edge after release
        @(negedge clk);
        rst_n = 1'b1;
        drive_now(1'b1, 1, 1'b0, 1'b0, 0, 1'b0, 6);
        mon_on = 1'b1;
        for (int k = 2; k <= 9; k++) begin
          @(negedge clk);
          drive_now(1'b1, k, 1'b0, 1'b0, 0, 1'b0, k + 5);
        end
        bubbles(1);
        issue(1'b1, 12, 1'b0, 1'b0, 0, 1'b0);
        bubbles(8);
        // R4: taken branch, six followers squashed, then target stream
        issue(1'b1, 20, 1'b1, 1'b1, 50, 1'b0);
        for (int k = 21; k <= 26; k++) issue(1'b1, k, 1'b0, 1'b0, 0, 1'b0);
        for (int k = 50; k <= 53; k++) issue(1'b1, k, 1'b0, 1'b0, 0, 1'b0);
        // R5: not-taken branch squashes nothing
        issue(1'b1, 30, 1'b1, 1'b0, 77, 1'b0);
        for (int k = 31; k <= 35; k++) issue(1'b1, k, 1'b0, 1'b0, 0, 1'b0);
        // R6: stall with a full pipeline and a tag held on the input
        for (int k = 40; k <= 45; k++) issue(1'b1, k, 1'b0, 1'b0, 0, 1'b0);
        for (int k = 0; k < 3; k++) issue(1'b1, 99, 1'b1, 1'b1, 98, 1'b1);
        issue(1'b1, 46, 1'b0, 1'b0, 0, 1'b0);
        issue(1'b1, 47, 1'b0, 1'b0, 0, 1'b0);
        // R4 with a stall inside the branch shadow
        issue(1'b1, 60, 1'b1, 1'b1, 70, 1'b0);
        issue(1'b1, 61, 1'b0, 1'b0, 0, 1'b0);
        issue(1'b1, 62, 1'b0, 1'b0, 0, 1'b1);
        for (int k = 63; k <= 67; k++) issue(1'b1, k, 1'b0, 1'b0, 0, 1'b0);
        issue(1'b1, 70, 1'b0, 1'b0, 0, 1'b0);
        // R5: taken branch inside another branch's shadow must not redirect
        issue(1'b1, 80, 1'b1, 1'b1, 90, 1'b0);
        issue(1'b1, 81, 1'b1, 1'b1, 95, 1'b0);
        for (int k = 82; k <= 85; k++) issue(1'b1, k, 1'b0, 1'b0, 0, 1'b0);
        issue(1'b1, 86, 1'b1, 1'b1, 96, 1'b0);
        issue(1'b1, 90, 1'b0, 1'b0, 0, 1'b0);
        issue(1'b1, 91, 1'b0, 1'b0, 0, 1'b0);
        bubbles(10);
        #1;
        chk(exp_q.size() == 0, "R2 drained", exp_q.size(), 0);
        chk(retired_count == popped[CNT_W-1:0], "R7 count", retired_count, popped);
        chk(stage_valid == 6'b0, "R2 empty", stage_valid, 0);
      end
      begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule